// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Clock-Factor Select

This block turns an asynchronous serial line into bytes. A separate receive clock, running at 1, 16 or 64 times the bit rate, is brought into the system clock domain and edge-detected there. Each rising edge of the receive clock counts as one sampling tick. In the 16x and 64x modes, a falling edge on the line has to hold until mid-bit before it counts as a start bit. Data bits are then sampled at their centres, least significant bit first. An optional parity bit follows, then the stop bit.

A finished character moves from the shift register into a holding register, so the next character can be shifted in while software has not yet read the last one. A ready flag shows that the holding register is full. Parity, framing and overrun errors are held in sticky flags until a clear pulse.

Character length, parity enable, parity sense and clock factor are plain configuration inputs. They are changed only while the line is idle.

Top module: `async_rx_top`

## Requirements
- R1: `factor_i` selects the ticks per bit: 0 gives 1, 1 gives 16, and 2 or 3 give 64. Each frame bit is sampled once per that many receive-clock rising edges.
- R2: The receive clock and the line both pass through a two-stage synchronizer. A rising edge of the receive clock yields exactly one single-cycle tick.
- R3: In the 16x and 64x modes, a low line is accepted as a start bit only if it is still low half a bit later. Otherwise the receiver stays idle and delivers nothing. In the 1x mode the first low sample starts a frame.
- R4: `char_len_i` values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. The first data bit received lands in `data_o[0]`, and unused upper bits of `data_o` read as zero.
- R5: With `parity_en_i` high, one parity bit follows the data bits. With `parity_odd_i` low the data plus parity must hold an even number of ones, and with it high an odd number. A mismatch sets `perr_o`.
- R6: A stop bit sampled low sets `ferr_o`. The character is still delivered.
- R7: A character is copied to the holding register when its stop bit is sampled. `data_o` keeps its value while the next frame is being shifted in.
- R8: `ready_o` sets when the holding register is loaded and clears on a one-cycle `rd_i` pulse.
- R9: A load while `ready_o` is still set, with no read in the same cycle, sets `oerr_o`. The new character replaces the old one.
- R10: `perr_o`, `ferr_o` and `oerr_o` stay set, even across reads, until an `err_clr_i` pulse. A new error arriving in the same cycle as the clear wins over the clear.
- R11: After reset, `data_o` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxc_i | input | 1 | Receive clock, asynchronous to clk_i |
| rxd_i | input | 1 | Serial line, idle high |
| factor_i | input | 2 | Clock factor select: 0 is 1x, 1 is 16x, 2 or 3 is 64x |
| char_len_i | input | 2 | Data bits minus five |
| parity_en_i | input | 1 | Enables the parity bit |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| rd_i | input | 1 | Read pulse, clears ready |
| err_clr_i | input | 1 | Clears the error flags |
| data_o | output | 8 | Holding register |
| ready_o | output | 1 | Holding register full |
| perr_o | output | 1 | Parity error, sticky |
| ferr_o | output | 1 | Framing error, sticky |
| oerr_o | output | 1 | Overrun error, sticky |

## Verification
The assertions assume three things about the inputs:
- The receive clock is slow enough that each of its levels spans several system clocks.
- The configuration inputs hold still for a whole frame.
- `rd_i` and `err_clr_i` arrive as short pulses.

The stimulus keeps to these limits. Its receive clock is 32 system clocks per period in the 1x mode and 6 in the faster modes. Clock factor, length and parity are changed only after each frame has ended and two idle bits have followed. Line transitions fall on falling edges of the receive clock, so the synchronized sampling edges land at bit centres.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MIN_BITS = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/rx_clk_edge.sv
module rx_clk_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxc_i,
  input  logic rxd_i,
  output logic tick_o,
  output logic rxd_o
);
  logic [SYNC_STAGES-1:0] rxc_q, rxd_q;
  logic                   rxc_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxc_q      <= '1;
      rxd_q      <= '1;
      rxc_last_q <= 1'b1;
    end else begin
      rxc_q      <= {rxc_q[SYNC_STAGES-2:0], rxc_i};
      rxd_q      <= {rxd_q[SYNC_STAGES-2:0], rxd_i};
      rxc_last_q <= rxc_q[SYNC_STAGES-1];
    end
  end

  assign tick_o = rxc_q[SYNC_STAGES-1] & ~rxc_last_q;
  assign rxd_o  = rxd_q[SYNC_STAGES-1];

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int unsigned LO_FACTOR = 16,
  parameter int unsigned HI_FACTOR = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rxd_i,
  input  logic [1:0]       factor_i,
  input  logic [1:0]       char_len_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  output logic             load_o,
  output rx_pkg::rx_char_t char_o
);
  import rx_pkg::*;
  localparam int unsigned CW = $clog2(HI_FACTOR);
  localparam int unsigned DW = DATA_W;

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q, last_cnt, half_cnt;
  logic [3:0]    bit_q, len_bits, shamt;
  logic [DW-1:0] sh_q, aligned;
  logic          pbit_q, at_last, x1_mode;
  int unsigned   n_ticks;

  always_comb begin
    unique case (factor_i)
      2'd0:    n_ticks = 1;
      2'd1:    n_ticks = LO_FACTOR;
      default: n_ticks = HI_FACTOR;
    endcase
  end

  assign x1_mode  = (factor_i == 2'd0);
  assign last_cnt = CW'(n_ticks - 1);
  assign half_cnt = CW'((n_ticks / 2) - 1);
  assign at_last  = (cnt_q == last_cnt);
  assign len_bits = {2'b00, char_len_i} + 4'(MIN_BITS);
  assign shamt    = 4'(DW) - len_bits;
  assign aligned  = sh_q >> shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        RX_IDLE: if (!rxd_i) begin
          cnt_q   <= '0;
          bit_q   <= '0;
          sh_q    <= '0;
          state_q <= x1_mode ? RX_DATA : RX_START;
        end
        RX_START: begin
          if (cnt_q == half_cnt) begin
            cnt_q   <= '0;
            state_q <= rxd_i ? RX_IDLE : RX_DATA; // high again: noise
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          cnt_q <= at_last ? '0 : cnt_q + 1'b1;
          if (at_last) begin
            sh_q  <= {rxd_i, sh_q[DW-1:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == len_bits - 1'b1) state_q <= parity_en_i ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          cnt_q <= at_last ? '0 : cnt_q + 1'b1;
          if (at_last) begin
            pbit_q  <= rxd_i;
            state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          cnt_q <= at_last ? '0 : cnt_q + 1'b1;
          if (at_last) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= 1'b0;
      char_o <= '0;
    end else begin
      load_o <= tick_i && (state_q == RX_STOP) && at_last;
      if (tick_i && (state_q == RX_STOP) && at_last) begin
        char_o.data <= aligned;
        char_o.perr <= parity_en_i && (pbit_q != ((^aligned) ^ parity_odd_i));
        char_o.ferr <= !rxd_i;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != RX_IDLE) |-> (32'(cnt_q) < n_ticks)); // R1
  AST_START_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START) |-> (cnt_q <= half_cnt)); // R3
  AST_X1_NO_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x1_mode |-> (state_q != RX_START)); // R3
endmodule

// File: rtl/rx_hold.sv
module rx_hold (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  rx_pkg::rx_char_t          char_i,
  input  logic                      rd_i,
  input  logic                      err_clr_i,
  output logic [rx_pkg::DATA_W-1:0] data_o,
  output logic                      ready_o,
  output logic                      perr_o,
  output logic                      ferr_o,
  output logic                      oerr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      oerr_o  <= 1'b0;
    end else begin
      if (load_i) data_o <= char_i.data;
      if (load_i)    ready_o <= 1'b1;
      else if (rd_i) ready_o <= 1'b0;
      // a fresh error outranks a simultaneous clear
      perr_o <= (perr_o & ~err_clr_i) | (load_i & char_i.perr);
      ferr_o <= (ferr_o & ~err_clr_i) | (load_i & char_i.ferr);
      oerr_o <= (oerr_o & ~err_clr_i) | (load_i & ready_o & ~rd_i);
    end
  end

  AST_READY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ready_o); // R8
  AST_READY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i) |=> !ready_o); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o)); // R7
  AST_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ready_o && !rd_i) |=> oerr_o); // R9
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !load_i) |=> !(perr_o || ferr_o || oerr_o)); // R10
endmodule

// File: rtl/async_rx_top.sv
module async_rx_top #(
  parameter int unsigned LO_FACTOR   = 16,
  parameter int unsigned HI_FACTOR   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxc_i,
  input  logic       rxd_i,
  input  logic [1:0] factor_i,
  input  logic [1:0] char_len_i,
  input  logic       parity_en_i,
  input  logic       parity_odd_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       oerr_o
);
  logic             tick, rxd_s, load;
  rx_pkg::rx_char_t chr;

  rx_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxc_i(rxc_i), .rxd_i(rxd_i),
    .tick_o(tick), .rxd_o(rxd_s)
  );

  rx_shifter #(.LO_FACTOR(LO_FACTOR), .HI_FACTOR(HI_FACTOR)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_s),
    .factor_i(factor_i), .char_len_i(char_len_i),
    .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
    .load_o(load), .char_o(chr)
  );

  rx_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .char_i(chr),
    .rd_i(rd_i), .err_clr_i(err_clr_i), .data_o(data_o),
    .ready_o(ready_o), .perr_o(perr_o), .ferr_o(ferr_o), .oerr_o(oerr_o)
  );
endmodule

// File: tb/tb_async_rx_top.sv
module tb_async_rx_top;
  logic       clk = 1'b0, rst_n = 1'b0, rxc = 1'b0, rxd = 1'b1;
  logic [1:0] factor = 2'd0, clen = 2'd3;
  logic       pen = 1'b0, podd = 1'b0, rd = 1'b0, eclr = 1'b0;
  logic [7:0] data;
  logic       ready, perr, ferr, oerr;
  int         total = 0, bad = 0, rxc_half = 16, rxc_cnt = 0;
  bit         done = 1'b0;

  async_rx_top dut (
    .clk_i(clk), .rst_ni(rst_n), .rxc_i(rxc), .rxd_i(rxd), .factor_i(factor),
    .char_len_i(clen), .parity_en_i(pen), .parity_odd_i(podd), .rd_i(rd),
    .err_clr_i(eclr), .data_o(data), .ready_o(ready), .perr_o(perr),
    .ferr_o(ferr), .oerr_o(oerr)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rxc_cnt >= rxc_half - 1) begin
      rxc_cnt <= 0;
      rxc <= ~rxc;
    end else rxc_cnt <= rxc_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int ticks(input logic [1:0] f);
    return (f == 2'd0) ? 1 : (f == 2'd1) ? 16 : 64;
  endfunction

  function automatic logic [7:0] mask_data(input logic [7:0] d, input int len);
    return d & 8'((1 << len) - 1);
  endfunction

  task automatic config_rx(input logic [1:0] f, input int len, input logic pe, input logic po);
    factor = f; clen = 2'(len - 5); pen = pe; podd = po;
    rxc_half = (f == 2'd0) ? 16 : 3;
    repeat (40) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    @(negedge rxc);
    rxd = b;
    repeat (ticks(factor) - 1) @(negedge rxc);
  endtask

  task automatic send_frame(input logic [7:0] d, input int len, input logic pcor, input logic sbad);
    logic [7:0] m;
    m = mask_data(d, len);
    drive_bit(1'b0);
    for (int i = 0; i < len; i++) drive_bit(m[i]);
    if (pen) drive_bit((^m) ^ podd ^ pcor);
    drive_bit(!sbad);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pulse(input logic do_rd, input logic do_clr);
    @(negedge clk); rd = do_rd; eclr = do_clr;
    @(negedge clk); rd = 1'b0; eclr = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_char(input string tag, input logic [7:0] d, input logic pe, input logic fe, input logic oe);
    @(negedge clk);
    check({tag, " data"}, 32'(data), 32'(d));
    check({tag, " ready R8"}, 32'(ready), 32'd1);
    check({tag, " perr R5"}, 32'(perr), 32'(pe));
    check({tag, " ferr R6"}, 32'(ferr), 32'(fe));
    check({tag, " oerr R9"}, 32'(oerr), 32'(oe));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check("R11 data", 32'(data), 0);
    check("R11 flags", {ready, perr, ferr, oerr}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 after release", {data, ready, perr, ferr, oerr}, 0);

    // R1 R4: 1x, 8 bits, no parity
    config_rx(2'd0, 8, 1'b0, 1'b0);
    send_frame(8'hA5, 8, 1'b0, 1'b0);
    expect_char("R1 R4 x1", 8'hA5, 0, 0, 0);
    pulse(1'b1, 1'b1);
    check("R8 ready cleared", 32'(ready), 0);

    // R4 R5: 16x, 5 bits, even parity, upper bits zero
    config_rx(2'd1, 5, 1'b1, 1'b0);
    send_frame(8'hF3, 5, 1'b0, 1'b0);
    expect_char("R4 R5 x16 len5", 8'h13, 0, 0, 0);
    pulse(1'b1, 1'b1);

    // R5: 64x (code 3), 7 bits, odd parity, corrupted
    config_rx(2'd3, 7, 1'b1, 1'b1);
    send_frame(8'h4C, 7, 1'b1, 1'b0);
    expect_char("R5 R1 x64 bad parity", 8'h4C, 1, 0, 0);
    // R10: read alone leaves error sticky
    pulse(1'b1, 1'b0);
    check("R10 perr sticky after read", 32'(perr), 1);
    check("R8 ready after read", 32'(ready), 0);
    pulse(1'b0, 1'b1);
    check("R10 perr cleared", 32'(perr), 0);

    // R6: framing error still delivers
    config_rx(2'd1, 8, 1'b0, 1'b0);
    send_frame(8'h3C, 8, 1'b0, 1'b1);
    expect_char("R6 framing", 8'h3C, 0, 1, 0);
    pulse(1'b1, 1'b1);
    check("R10 ferr cleared", 32'(ferr), 0);

    // R7 R9: double buffer and overrun
    send_frame(8'h11, 8, 1'b0, 1'b0);
    fork
      send_frame(8'h22, 8, 1'b0, 1'b0);
      begin
        repeat (5 * 16) @(negedge rxc);
        @(negedge clk);
        check("R7 hold kept mid frame", 32'(data), 32'h11);
        check("R7 ready kept mid frame", 32'(ready), 1);
      end
    join
    expect_char("R9 overrun", 8'h22, 0, 0, 1);
    pulse(1'b1, 1'b1);
    check("R10 oerr cleared", 32'(oerr), 0);

    // R3: short low pulse rejected in 16x
    config_rx(2'd1, 8, 1'b0, 1'b0);
    @(negedge rxc); rxd = 1'b0;
    repeat (6) @(negedge rxc);
    rxd = 1'b1;
    repeat (40 * 16) @(negedge rxc);
    @(negedge clk);
    check("R3 noise ignored ready", 32'(ready), 0);
    check("R3 noise ignored flags", {perr, ferr, oerr}, 0);
    send_frame(8'h5A, 8, 1'b0, 1'b0);
    expect_char("R3 frame after noise", 8'h5A, 0, 0, 0);
    pulse(1'b1, 1'b1);

    // R2 R1 R4 R5 R6: random frames
    for (int n = 0; n < 20; n++) begin
      logic [1:0] f;
      int         len;
      logic [7:0] d;
      logic       pe, po, pc, sb;
      f   = ($urandom % 4 == 3) ? 2'($urandom % 2 + 2) : 2'($urandom % 2);
      len = 5 + int'($urandom % 4);
      d   = 8'($urandom);
      pe  = 1'($urandom);
      po  = 1'($urandom);
      pc  = pe && ($urandom % 5 == 0);
      sb  = ($urandom % 6 == 0);
      config_rx(f, len, pe, po);
      send_frame(d, len, pc, sb);
      expect_char("R2 random", mask_data(d, len), pc, sb, 0);
      pulse(1'b1, 1'b1);
    end
    finish_run();
  end
endmodule